// File: doc/BRIEF.md
# Directory Occupancy Arbiter

This block is the commit gate of one directory in a transactional memory system where transactions keep their updates private until commit. Before a transaction may push its updates into the directory, it must occupy the directory. The arbiter keeps the set of current holders and whether they hold for writing or for reading only. It takes occupy, release and abort-notify requests from up to `NTX` transactions. Each request carries a transaction ID, a write flag and a commit timestamp. Every accepted request gets exactly one response: grant, buffered, refused (NACK) or done.

Readers may share the directory. A writer needs it alone. When a request conflicts, it can steal the directory if the directory has exactly one holder and the request is older than that holder. A smaller timestamp means older. Otherwise the request is either parked in a small wait queue or refused, as chosen by a mode input.

Requests enter on a valid/ready channel. A request moves when `req_valid` and `req_ready` are both high at a rising edge. The arbiter lowers `req_ready` only while it is granting a waiting request from its queue, which uses the response port in that cycle. The response and preempt outputs are one-cycle pulses with no back-pressure. The holder of a preempt or grant must be able to take them in any cycle.

Top module: `dir_occ_arbiter`

## Requirements
- R1: Each accepted request, and each queued request that is granted, produces exactly one `rsp_valid` pulse one clock later, with `rsp_tid` set to the requester. The response codes are 0 = grant, 1 = buffered, 2 = NACK and 3 = done. The request ops are 0 = occupy, 1 = release and 2 = abort-notify.
- R2: A writer occupy is granted only when the directory has no holders. While a writer holds the directory, `writer_held` is 1 and `reader_count` is 0.
- R3: A reader occupy is granted when there are no holders or only reader holders. `reader_count` equals the number of reader holders.
- R4: With `buf_mode` = 0, an occupy that conflicts and cannot steal gets a NACK and leaves the occupancy unchanged.
- R5: A conflicting occupy steals the directory only when there is exactly one holder and the request timestamp is strictly smaller than that holder's timestamp. An equal or larger timestamp never steals. A steal grants the requester. In the same response cycle it pulses `preempt_valid` for one cycle with the victim in `preempt_tid`, and the victim no longer holds the directory.
- R6: With `buf_mode` = 1, a conflicting occupy that cannot steal gets the buffered response and enters a wait queue of `QDEPTH` entries. If the queue is full, the occupy gets a NACK instead.
- R7: While the head of the queue can be granted (no holders, or a reader head while only readers hold), `req_ready` is 0. The head is granted, and heads are served in arrival order. Consecutive reader heads are granted on consecutive cycles.
- R8: A release or an abort-notify from a holder clears its hold and answers done. The same op from a non-holder answers NACK and changes nothing.
- R9: After reset there are no holders, the queue is empty, `req_ready` is 1 and no pulse is raised.
- R10: Op code 3 answers NACK and changes nothing. A repeat occupy from a current holder is granted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_mode | input | 1 | 1: queue conflicting requests; 0: NACK them |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 occupy, 1 release, 2 abort-notify, 3 reserved |
| req_tid | input | $clog2(NTX) | Requesting transaction |
| req_write | input | 1 | Occupy for writing (1) or reading (0) |
| req_ts | input | TS_W | Commit timestamp, smaller is older |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | 0 grant, 1 buffered, 2 NACK, 3 done |
| rsp_tid | output | $clog2(NTX) | Transaction the response is for |
| preempt_valid | output | 1 | Steal pulse to the younger holder |
| preempt_tid | output | $clog2(NTX) | Victim of the steal |
| occupied | output | 1 | At least one holder |
| writer_held | output | 1 | Held by a writer |
| reader_count | output | $clog2(NTX+1) | Number of reader holders |

## Verification
The hardest state to reach is a full wait queue whose entries mix readers and writers, followed by the directory becoming free. That is where `req_ready` drops, reader heads drain back to back, and a writer head must wait for the last reader to leave. The directed stimulus holds the directory with a writer in buffered mode and fills the queue with readers then writers. It overflows the queue once, then releases the holders one by one. A long random phase then switches the mode, reuses IDs and draws timestamps from a narrow range, so equal-timestamp and steal cases occur often. A behavioural model checks the result on every clock.

// File: rtl/dir_occ_pkg.sv
package dir_occ_pkg;
  typedef enum logic [1:0] {
    OP_OCCUPY  = 2'd0,
    OP_RELEASE = 2'd1,
    OP_ABORT   = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RSP_GRANT  = 2'd0,
    RSP_BUFFER = 2'd1,
    RSP_NACK   = 2'd2,
    RSP_DONE   = 2'd3
  } rsp_e;
endpackage

// File: rtl/dir_holder_table.sv
module dir_holder_table #(
  parameter int NTX   = 8,
  parameter int TS_W  = 8,
  parameter int TID_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TID_W-1:0] set_tid,
  input  logic             set_write,
  input  logic [TS_W-1:0]  set_ts,
  input  logic             clr_en,
  input  logic [TID_W-1:0] clr_tid,
  output logic [NTX-1:0]   held,
  output logic [CNT_W-1:0] holder_cnt,
  output logic             write_mode,
  output logic [TID_W-1:0] sole_tid,
  output logic [TS_W-1:0]  sole_ts
);
  logic [TS_W-1:0] ts_q [NTX];

  for (genvar i = 0; i < NTX; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held[i] <= 1'b0;
        ts_q[i] <= '0;
      end else if (set_en && set_tid == TID_W'(i)) begin
        held[i] <= 1'b1;
        ts_q[i] <= set_ts;
      end else if (clr_en && clr_tid == TID_W'(i)) begin
        held[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          write_mode <= 1'b0;
    else if (set_en)                     write_mode <= set_write;
    else if (clr_en && holder_cnt == 1)  write_mode <= 1'b0;
  end

  always_comb begin
    holder_cnt = '0;
    sole_tid   = '0;
    for (int i = NTX - 1; i >= 0; i--) begin
      holder_cnt = holder_cnt + CNT_W'(held[i]);
      if (held[i]) sole_tid = TID_W'(i);
    end
  end

  assign sole_ts = ts_q[sole_tid];
endmodule

// File: rtl/dir_wait_fifo.sv
module dir_wait_fifo #(
  parameter int DW    = 12,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push && !full) begin
        mem[wr_ptr] <= push_data;
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop && !empty)
        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(push && !full) - CW'(pop && !empty);
    end
  end
endmodule

// File: rtl/dir_occ_arbiter.sv
module dir_occ_arbiter
  import dir_occ_pkg::*;
#(
  parameter int NTX    = 8,
  parameter int TS_W   = 8,
  parameter int QDEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       buf_mode,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [1:0]                 req_op,
  input  logic [$clog2(NTX)-1:0]     req_tid,
  input  logic                       req_write,
  input  logic [TS_W-1:0]            req_ts,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_code,
  output logic [$clog2(NTX)-1:0]     rsp_tid,
  output logic                       preempt_valid,
  output logic [$clog2(NTX)-1:0]     preempt_tid,
  output logic                       occupied,
  output logic                       writer_held,
  output logic [$clog2(NTX+1)-1:0]   reader_count
);
  localparam int TID_W = $clog2(NTX);
  localparam int CNT_W = $clog2(NTX + 1);
  localparam int QW    = TID_W + 1 + TS_W;

  logic [NTX-1:0]   held;
  logic [CNT_W-1:0] holder_cnt;
  logic             wmode;
  logic [TID_W-1:0] sole_tid;
  logic [TS_W-1:0]  sole_ts;

  logic             set_en, set_write, clr_en;
  logic [TID_W-1:0] set_tid, clr_tid;
  logic [TS_W-1:0]  set_ts;

  logic             q_push, q_pop, q_empty, q_full;
  logic [QW-1:0]    q_head;
  logic [TID_W-1:0] head_tid;
  logic             head_wr;
  logic [TS_W-1:0]  head_ts;

  logic             head_ok, accept, is_holder, compat;
  logic             rsp_v_d, pre_v_d;
  rsp_e             rsp_c_d;
  logic [TID_W-1:0] rsp_t_d, pre_t_d;

  dir_holder_table #(.NTX(NTX), .TS_W(TS_W), .TID_W(TID_W), .CNT_W(CNT_W)) u_holders (
    .clk, .rst_n,
    .set_en, .set_tid, .set_write, .set_ts,
    .clr_en, .clr_tid,
    .held, .holder_cnt, .write_mode(wmode), .sole_tid, .sole_ts
  );

  dir_wait_fifo #(.DW(QW), .DEPTH(QDEPTH)) u_waitq (
    .clk, .rst_n,
    .push(q_push), .push_data({req_tid, req_write, req_ts}),
    .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  assign {head_tid, head_wr, head_ts} = q_head;

  assign occupied     = (holder_cnt != '0);
  assign writer_held  = wmode;
  assign reader_count = wmode ? '0 : holder_cnt;

  // A waiting head that fits the current holders owns the response slot.
  assign head_ok   = !q_empty && (!occupied || (!wmode && !head_wr));
  assign req_ready = !head_ok;
  assign accept    = req_valid && req_ready;
  assign is_holder = held[req_tid];
  assign compat    = !occupied || (!req_write && !wmode);

  always_comb begin
    set_en = 1'b0; set_tid = req_tid; set_write = req_write; set_ts = req_ts;
    clr_en = 1'b0; clr_tid = req_tid;
    q_push = 1'b0; q_pop = 1'b0;
    rsp_v_d = 1'b0; rsp_c_d = RSP_NACK; rsp_t_d = req_tid;
    pre_v_d = 1'b0; pre_t_d = sole_tid;
    if (head_ok) begin
      set_en = 1'b1; set_tid = head_tid; set_write = head_wr; set_ts = head_ts;
      q_pop = 1'b1;
      rsp_v_d = 1'b1; rsp_c_d = RSP_GRANT; rsp_t_d = head_tid;
    end else if (accept) begin
      rsp_v_d = 1'b1;
      case (op_e'(req_op))
        OP_OCCUPY: begin
          if (is_holder) begin
            rsp_c_d = RSP_GRANT;
          end else if (compat) begin
            set_en = 1'b1;
            rsp_c_d = RSP_GRANT;
          end else if (holder_cnt == CNT_W'(1) && req_ts < sole_ts) begin
            set_en = 1'b1;
            clr_en = 1'b1; clr_tid = sole_tid;
            pre_v_d = 1'b1;
            rsp_c_d = RSP_GRANT;
          end else if (buf_mode && !q_full) begin
            q_push = 1'b1;
            rsp_c_d = RSP_BUFFER;
          end
        end
        OP_RELEASE, OP_ABORT: begin
          if (is_holder) begin
            clr_en = 1'b1;
            rsp_c_d = RSP_DONE;
          end
        end
        default: rsp_c_d = RSP_NACK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_code      <= 2'd0;
      rsp_tid       <= '0;
      preempt_valid <= 1'b0;
      preempt_tid   <= '0;
    end else begin
      rsp_valid     <= rsp_v_d;
      rsp_code      <= rsp_c_d;
      rsp_tid       <= rsp_t_d;
      preempt_valid <= pre_v_d;
      preempt_tid   <= pre_t_d;
    end
  end
endmodule

// File: rtl/dir_occ_checker.sv
module dir_occ_checker #(
  parameter int NTX  = 8,
  parameter int TS_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic [1:0]               rsp_code,
  input logic [$clog2(NTX)-1:0]   rsp_tid,
  input logic                     preempt_valid,
  input logic [$clog2(NTX)-1:0]   preempt_tid,
  input logic                     occupied,
  input logic                     writer_held,
  input logic [$clog2(NTX+1)-1:0] reader_count
);
  assert_rsp_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid || !req_ready));

  assert_writer_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    writer_held |-> (occupied && reader_count == '0));

  assert_steal_grants_R5: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_valid |-> (rsp_valid && rsp_code == 2'd0 && preempt_tid != rsp_tid));

  assert_buffer_when_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd1) |-> occupied);

  assert_stall_no_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !writer_held);
endmodule

bind dir_occ_arbiter dir_occ_checker #(.NTX(NTX), .TS_W(TS_W)) u_occ_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_tid(rsp_tid),
  .preempt_valid(preempt_valid), .preempt_tid(preempt_tid),
  .occupied(occupied), .writer_held(writer_held), .reader_count(reader_count)
);

// File: tb/tb_dir_occ_arbiter.sv
module tb_dir_occ_arbiter;
  localparam int NTX = 8;
  localparam int TS_W = 8;
  localparam int QD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic [2:0] req_tid = 3'd0;
  logic req_write = 1'b0;
  logic [TS_W-1:0] req_ts = '0;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic [2:0] rsp_tid;
  logic preempt_valid;
  logic [2:0] preempt_tid;
  logic occupied, writer_held;
  logic [3:0] reader_count;

  always #5 clk = ~clk;

  dir_occ_arbiter #(.NTX(NTX), .TS_W(TS_W), .QDEPTH(QD)) dut (
    .clk, .rst_n, .buf_mode, .req_valid, .req_ready, .req_op, .req_tid,
    .req_write, .req_ts, .rsp_valid, .rsp_code, .rsp_tid, .preempt_valid,
    .preempt_tid, .occupied, .writer_held, .reader_count
  );

  int checks = 0;
  int errors = 0;
  string tag = "R9";

  // Behavioural reference model
  typedef struct { int tid; bit wr; int ts; } ent_t;
  bit   m_held [NTX];
  int   m_ts [NTX];
  bit   m_w;
  ent_t m_q [$];
  bit   e_rv, e_pv;
  int   e_code, e_tid, e_ptid;

  function automatic int m_cnt();
    int c = 0;
    for (int i = 0; i < NTX; i++) c += m_held[i];
    return c;
  endfunction

  function automatic int m_sole();
    for (int i = 0; i < NTX; i++) if (m_held[i]) return i;
    return 0;
  endfunction

  function automatic bit m_head_ok();
    if (m_q.size() == 0) return 1'b0;
    return (m_cnt() == 0) || (!m_w && !m_q[0].wr);
  endfunction

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL [%s] %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_step(input bit v, input int op, input int tid, input bit wr, input int ts);
    int cnt, s;
    ent_t e;
    e_rv = 0; e_pv = 0; e_code = 2; e_tid = tid; e_ptid = 0;
    cnt = m_cnt();
    if (m_head_ok()) begin
      e = m_q.pop_front();
      m_held[e.tid] = 1; m_ts[e.tid] = e.ts; m_w = e.wr;
      e_rv = 1; e_code = 0; e_tid = e.tid;
    end else if (v) begin
      e_rv = 1;
      if (op == 0) begin
        s = m_sole();
        if (m_held[tid]) e_code = 0;
        else if (cnt == 0 || (!wr && !m_w)) begin
          m_held[tid] = 1; m_ts[tid] = ts; m_w = wr; e_code = 0;
        end else if (cnt == 1 && ts < m_ts[s]) begin
          m_held[s] = 0; m_held[tid] = 1; m_ts[tid] = ts; m_w = wr;
          e_code = 0; e_pv = 1; e_ptid = s;
        end else if (buf_mode && m_q.size() < QD) begin
          e.tid = tid; e.wr = wr; e.ts = ts; m_q.push_back(e); e_code = 1;
        end else e_code = 2;
      end else if (op == 1 || op == 2) begin
        if (m_held[tid]) begin
          m_held[tid] = 0; e_code = 3;
          if (m_cnt() == 0) m_w = 0;
        end else e_code = 2;
      end else e_code = 2;
    end
  endtask

  task automatic compare_state();
    int cnt;
    cnt = m_cnt();
    chk("rsp_valid", rsp_valid, e_rv);
    if (e_rv) begin
      chk("rsp_code", rsp_code, e_code);
      chk("rsp_tid", rsp_tid, e_tid);
    end
    chk("preempt_valid (R5)", preempt_valid, e_pv);
    if (e_pv) chk("preempt_tid (R5)", preempt_tid, e_ptid);
    chk("occupied", occupied, cnt != 0);
    chk("writer_held (R2)", writer_held, m_w);
    chk("reader_count (R3)", reader_count, m_w ? 0 : cnt);
  endtask

  // One clock: drive, check ready, advance model, compare after the edge.
  task automatic step(input bit v, input int op, input int tid, input bit wr, input int ts);
    req_valid = v; req_op = 2'(op); req_tid = 3'(tid); req_write = wr; req_ts = TS_W'(ts);
    #1;
    chk("req_ready (R7)", req_ready, !m_head_ok());
    model_step(v, op, tid, wr, ts);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    compare_state();
  endtask

  task automatic occ(input int tid, input bit wr, input int ts); step(1, 0, tid, wr, ts); endtask
  task automatic rel(input int tid); step(1, 1, tid, 0, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0); endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL [watchdog] run hung, got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NTX; i++) begin m_held[i] = 0; m_ts[i] = 0; end
    m_w = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    tag = "R9";
    #1;
    chk("req_ready after reset R9", req_ready, 1);
    chk("occupied after reset R9", occupied, 0);
    chk("rsp_valid after reset R9", rsp_valid, 0);
    chk("preempt_valid after reset R9", preempt_valid, 0);
    idle();

    // R2/R4: writer exclusive, NACK mode refuses conflicts
    tag = "R2"; occ(0, 1, 10);
    tag = "R4"; occ(1, 0, 20); occ(2, 1, 30);
    // R8: release from non-holder and holder
    tag = "R8"; rel(1); rel(0);
    // R3: readers share, older writer cannot steal from several readers
    tag = "R3"; occ(0, 0, 40); occ(1, 0, 41); occ(2, 0, 42);
    tag = "R4"; occ(3, 1, 0);
    tag = "R8"; step(1, 2, 0, 0, 0); rel(1); rel(2);
    // R5: steal rules
    tag = "R5"; occ(0, 1, 50); occ(1, 1, 50); occ(1, 1, 40);
    occ(2, 0, 41); occ(2, 0, 5); occ(3, 0, 60); rel(2); rel(3);
    // R10: reserved op and repeated occupy
    tag = "R10"; occ(4, 1, 9); step(1, 3, 4, 0, 0); occ(4, 0, 9); rel(4);
    // R6/R7: buffering, overflow, ordered drain
    buf_mode = 1'b1;
    tag = "R6"; occ(0, 1, 10); occ(1, 0, 20); occ(2, 0, 21); occ(3, 1, 22); occ(4, 1, 23);
    occ(5, 0, 24);
    tag = "R7"; rel(0); idle(); idle(); rel(1); rel(2); idle(); rel(3); idle(); rel(4);
    idle();

    // R1: random traffic against the model
    tag = "R1";
    for (int n = 0; n < 3000; n++) begin
      int r;
      if (n % 200 == 0) buf_mode = ~buf_mode;
      r = $urandom_range(0, 9);
      step($urandom_range(0, 3) != 0, (r < 5) ? 0 : (r < 8) ? 1 : (r < 9) ? 2 : 3,
           $urandom_range(0, NTX - 1), $urandom_range(0, 9) < 4, $urandom_range(0, 15));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule